// File: doc/BRIEF.md
# External Bus Address-Latch and Code-Read Strobe Generator

This block drives the two strobes that frame every external bus access of a 12-clock machine-cycle microcontroller core. It owns the phase counter that splits each machine cycle into two halves of six oscillator clocks. It produces an active-high address latch strobe (`ale_o`) and an active-low code read strobe (`psen_n_o`) from a small set of per-cycle flags. Those flags say whether the current cycle carries an external data access, whether it is a code-table read, and whether the core runs from external code memory. A software-held latch-disable bit is also part of the state.

The core presents its flags and any write to the disable bit before each machine cycle starts. The block snapshots them on the edge that moves the phase to 0 and holds them for the whole cycle, so the strobes never change shape halfway through a cycle. Both strobes come from registers, so they are free of glitches. The phase output lets the core line its own sequencing up with the strobes.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase_o` counts 0 to 11 and wraps to 0. While reset is held, `ale_o` is 0 and `psen_n_o` is 1. The first cycle after reset is released shows phase 0.
- R2: In a cycle with no data access and the disable bit clear, `ale_o` is 1 at phases 0, 1, 6 and 7 and 0 at all other phases.
- R3: In a data-access cycle (`xdata_i`=1), `ale_o` is 1 only at phases 0 and 1, and `psen_n_o` stays 1 for all 12 phases.
- R4: When `ext_code_i`=1 and `xdata_i`=0, `psen_n_o` is 0 at phases 2, 3, 4, 8, 9 and 10 and 1 elsewhere. When `ext_code_i`=0, `psen_n_o` stays 1. `ale_o` and a low `psen_n_o` never overlap.
- R5: With the disable bit set, `ext_code_i`=0, `xdata_i`=0 and `code_tbl_i`=0, `ale_o` stays 0 for the whole cycle.
- R6: With the disable bit set, a cycle with `xdata_i`=1 or `code_tbl_i`=1 still pulses `ale_o` as in R2 and R3.
- R7: With the disable bit set and `ext_code_i`=1, `ale_o` pulses exactly as with the bit clear.
- R8: The flags and the disable bit are sampled only on the clock edge where `phase_o` goes from 11 to 0. A write with `ale_off_we_i`=1 on that edge applies to the cycle it starts. Changes made at any other phase take effect from the next machine cycle.
- R9: Reset clears the disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xdata_i | input | 1 | Current cycle carries an external data access |
| code_tbl_i | input | 1 | Current cycle is a code-table read |
| ext_code_i | input | 1 | Core executes from external code memory |
| ale_off_we_i | input | 1 | Write strobe for the latch-disable bit |
| ale_off_d_i | input | 1 | Value written to the latch-disable bit |
| phase_o | output | 4 | Machine-cycle phase, 0 to 11 |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Code read strobe, active low |

## Verification
The bench builds the block with its default parameters: six clocks per half cycle, a two-clock latch pulse and a three-clock read pulse starting at sub-phase 2. With these values one 12-clock machine cycle is short enough to sweep all sixteen combinations of the three flags and the disable bit, checking both strobes at every phase against an arithmetic model. The same configuration makes it cheap to change a flag partway through a cycle and to reset with the disable bit set, which exercises the sampling rule and the reset value of the bit.

// File: rtl/busstrb_pkg.sv
package busstrb_pkg;

  // Per-machine-cycle context, captured when the phase wraps to 0.
  typedef struct packed {
    logic xdata;   // external data access this cycle
    logic tbl;     // code-table read this cycle
    logic ext;     // executing from external code memory
    logic off;     // latch-disable bit
  } cyc_ctx_t;

endpackage

// File: rtl/busstrb_phase_ctr.sv
module busstrb_phase_ctr #(
  parameter int CYCLE_CLKS = 12,
  parameter int PW = $clog2(CYCLE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nxt,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(CYCLE_CLKS - 1);

  assign wrap      = (phase_q == LAST);
  assign phase_nxt = wrap ? '0 : phase_q + 1'b1;

  // Held at LAST during reset so that the first edge after release enters phase 0.
  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= LAST;
    else        phase_q <= phase_nxt;
  end

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == LAST) |=> (phase_q == '0));
  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
endmodule

// File: rtl/busstrb_ctx.sv
module busstrb_ctx
  import busstrb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrap,
  input  logic     xdata_i,
  input  logic     code_tbl_i,
  input  logic     ext_code_i,
  input  logic     off_we_i,
  input  logic     off_d_i,
  output cyc_ctx_t ctx_q,
  output cyc_ctx_t ctx_nxt
);
  logic off_q;
  logic off_nxt;

  assign off_nxt = off_we_i ? off_d_i : off_q;

  always_comb begin
    ctx_nxt = ctx_q;
    if (wrap) begin
      ctx_nxt.xdata = xdata_i;
      ctx_nxt.tbl   = code_tbl_i;
      ctx_nxt.ext   = ext_code_i;
      ctx_nxt.off   = off_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      ctx_q <= '0;
    end else begin
      off_q <= off_nxt;
      ctx_q <= ctx_nxt;
    end
  end

  // Context must not move except on the wrap edge.
  assert_ctx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ctx_q));
endmodule

// File: rtl/busstrb_decode.sv
module busstrb_decode
  import busstrb_pkg::*;
#(
  parameter int HALF_CLKS  = 6,
  parameter int ALE_W      = 2,
  parameter int RD_START   = 2,
  parameter int RD_W       = 3,
  parameter int PW         = $clog2(2 * HALF_CLKS)
) (
  input  logic [PW-1:0] phase,
  input  cyc_ctx_t      ctx,
  output logic          ale,
  output logic          psen_n
);
  localparam logic [PW-1:0] HALF_P  = PW'(HALF_CLKS);
  localparam logic [PW-1:0] ALE_END = PW'(ALE_W);
  localparam logic [PW-1:0] RD_LO   = PW'(RD_START);
  localparam logic [PW-1:0] RD_HI   = PW'(RD_START + RD_W);

  logic          second_half;
  logic [PW-1:0] sub;
  logic          ale_slot;
  logic          rd_slot;
  logic          ale_allowed;

  assign second_half = (phase >= HALF_P);
  assign sub         = second_half ? phase - HALF_P : phase;
  assign ale_slot    = (sub < ALE_END);
  assign rd_slot     = (sub >= RD_LO) && (sub < RD_HI);

  // Disable bit is overridden by external execution and by data/table cycles.
  assign ale_allowed = !ctx.off || ctx.ext || ctx.xdata || ctx.tbl;

  assign ale    = ale_slot && ale_allowed && !(ctx.xdata && second_half);
  assign psen_n = !(rd_slot && ctx.ext && !ctx.xdata);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import busstrb_pkg::*;
#(
  parameter int HALF_CLKS = 6,
  parameter int ALE_W     = 2,
  parameter int RD_START  = 2,
  parameter int RD_W      = 3,
  parameter int CYCLE_CLKS = 2 * HALF_CLKS,
  parameter int PW         = $clog2(CYCLE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xdata_i,
  input  logic          code_tbl_i,
  input  logic          ext_code_i,
  input  logic          ale_off_we_i,
  input  logic          ale_off_d_i,
  output logic [PW-1:0] phase_o,
  output logic          ale_o,
  output logic          psen_n_o
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;
  logic          wrap;
  cyc_ctx_t      ctx_q;
  cyc_ctx_t      ctx_nxt;
  logic          ale_d;
  logic          psen_n_d;

  busstrb_phase_ctr #(.CYCLE_CLKS(CYCLE_CLKS), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_nxt(phase_nxt), .wrap(wrap)
  );

  busstrb_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .wrap(wrap),
    .xdata_i(xdata_i), .code_tbl_i(code_tbl_i), .ext_code_i(ext_code_i),
    .off_we_i(ale_off_we_i), .off_d_i(ale_off_d_i),
    .ctx_q(ctx_q), .ctx_nxt(ctx_nxt)
  );

  // Decode for the upcoming phase, then register so the strobes are glitch-free.
  busstrb_decode #(
    .HALF_CLKS(HALF_CLKS), .ALE_W(ALE_W), .RD_START(RD_START), .RD_W(RD_W), .PW(PW)
  ) u_dec (
    .phase(phase_nxt), .ctx(ctx_nxt), .ale(ale_d), .psen_n(psen_n_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_o    <= 1'b0;
      psen_n_o <= 1'b1;
    end else begin
      ale_o    <= ale_d;
      psen_n_o <= psen_n_d;
    end
  end

  assign phase_o = phase_q;

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && !psen_n_o));
  assert_rd_quiet_xdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_q.xdata |-> psen_n_o);
  assert_rd_quiet_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_q.ext |-> psen_n_o);
  assert_ale_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.off && !ctx_q.ext && !ctx_q.xdata && !ctx_q.tbl) |-> !ale_o);
  assert_ale_second_half_xdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.xdata && phase_q >= PW'(HALF_CLKS)) |-> !ale_o);
  assert_reset_outputs_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!ale_o && psen_n_o));
endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xdata = 1'b0, tbl = 1'b0, ext = 1'b0, we = 1'b0, din = 1'b0;
  logic [3:0] phase;
  logic       ale, psen_n;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .xdata_i(xdata), .code_tbl_i(tbl), .ext_code_i(ext),
    .ale_off_we_i(we), .ale_off_d_i(din),
    .phase_o(phase), .ale_o(ale), .psen_n_o(psen_n)
  );

  function automatic logic exp_ale(int p, logic x, logic c, logic e, logic d);
    int sub = p % 6;
    int h   = p / 6;
    return (sub < 2) && !(x && h == 1) && (!d || e || x || c);
  endfunction

  function automatic logic exp_psen_n(int p, logic x, logic e);
    int sub = p % 6;
    return !(e && !x && sub >= 2 && sub < 5);
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s phase=%0d actual=%0b expected=%0b", req, what, phase, act, exp);
    end
  endtask

  task automatic wait_last();
    while (phase != 4'd11) @(negedge clk);
  endtask

  // Drive one machine cycle's context at phase 11 and check every phase of it.
  task automatic run_cycle(string req, logic x, logic c, logic e, logic wr, logic d, logic d_eff);
    wait_last();
    xdata = x; tbl = c; ext = e; we = wr; din = d;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      we = 1'b0;
      checks++;
      if (phase != k[3:0]) begin
        failures++;
        $display("FAIL R1 phase actual=%0d expected=%0d", phase, k);
      end
      chk(req, ale, exp_ale(k, x, c, e, d_eff), "ale");
      chk(req, psen_n, exp_psen_n(k, x, e), "psen_n");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", ale, 1'b0, "reset ale");
    chk("R1", psen_n, 1'b1, "reset psen_n");
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (phase != 4'd0) begin
      failures++;
      $display("FAIL R1 first phase actual=%0d expected=0", phase);
    end

    // Exhaustive sweep: R2 R3 R4 R5 R6 R7 over all flag/disable combinations.
    for (int v = 0; v < 16; v++) begin
      logic x = v[0], c = v[1], e = v[2], d = v[3];
      string r;
      if (x) r = "R3";
      else if (d && !e && !c) r = "R5";
      else if (d && c) r = "R6";
      else if (d && e) r = "R7";
      else if (e) r = "R4";
      else r = "R2";
      run_cycle(r, x, c, e, 1'b1, d, d);
    end

    // R8: mid-cycle change of flags and disable bit has no effect until the next cycle.
    run_cycle("R8", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_last();
    ext = 1'b1; xdata = 1'b0; tbl = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 4) begin ext = 1'b0; xdata = 1'b1; we = 1'b1; din = 1'b1; end
      if (k == 5) we = 1'b0;
      chk("R8", ale, exp_ale(k, 1'b0, 1'b0, 1'b1, 1'b0), "ale mid-cycle");
      chk("R8", psen_n, exp_psen_n(k, 1'b0, 1'b1), "psen_n mid-cycle");
    end
    // Next cycle sees disable=1 written mid-cycle; internal, plain cycle -> quiet.
    run_cycle("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R9: reset clears the disable bit.
    run_cycle("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_cycle("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule